// File: doc/BRIEF.md
# Indexed DAC Register Port

This block is the host-facing register slave of a video digital-to-analog converter. A host reaches it through a sixteen-byte direct window using single-cycle byte read and write strobes. One direct byte holds an index and another is a data port. Through these two bytes the host reads and writes a 64-entry file of extended registers.

Part of the extended space drives three synthesizers: pixel, memory and loop. Each synthesizer keeps three parameter bytes. One packed address register holds a 2-bit byte pointer for each synthesizer, and each synthesizer has its own data port. Every access to a data port steps that synthesizer's pointer. A write sets the loading sequence 0, 1, 2. A read reports the lock flag in bit 6. Lock is modelled by a cycle counter that restarts whenever a parameter byte is rewritten. The parameter bytes are brought out so the clock generators can use them.

Top module: `dac_idx_port`

## Requirements
- R1: Direct offsets 0x00 to 0x0F are valid. Offset 0x00 holds the extended index and reads it back. Every offset other than 0x00 and 0x0A is a plain read/write byte.
- R2: An access at a direct offset of 0x10 or above is invalid. A read returns 0x00 and a write changes nothing. Either one raises `err_o` for exactly the cycle after the access. A valid access leaves `err_o` low.
- R3: Offset 0x0A reads or writes the extended register chosen by the index. Indices 0x00 to 0x3F, other than 0x2C to 0x2F, are plain read/write bytes.
- R4: An index of 0x40 or above is invalid at offset 0x0A. A read returns 0x00 with the error pulse, and a write changes no register and raises the error pulse.
- R5: Read data appears on `rdata_o` with `rvalid_o` high in the cycle after `rd_en_i`. A write strobe in the same cycle takes precedence and suppresses the read.
- R6: Extended 0x2C packs the byte pointers: pixel in bits [1:0], memory in bits [3:2] and loop in bits [5:4]. A write loads all three pointers. A read returns them with bits [7:6] zero.
- R7: Extended 0x2D, 0x2E and 0x2F are the data ports of the pixel, memory and loop synthesizers. A write stores the byte at that synthesizer's current pointer. Byte j of synthesizer k appears on `pll_param_o[(3k+j)*8 +: 8]`, with k = 0 for pixel.
- R8: Each read or write of a data port advances only that synthesizer's pointer, in the order 0, 1, 2, 0. A pointer of 3 also moves to 0.
- R9: A data-port read returns the pointed byte with bit 6 replaced by the lock flag. With a pointer of 3, a read returns only the lock flag in bit 6, and a write stores nothing and leaves lock untouched.
- R10: Storing a parameter byte clears that synthesizer's lock on that edge. Lock sets again exactly LOCK_CYCLES clocks later unless the synthesizer is rewritten first. A rewrite on the edge where the count would expire wins, and lock stays clear.
- R11: Reset clears the index, every register, every parameter byte and every pointer. After reset each synthesizer counts toward lock as though it had just been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte write strobe |
| rd_en_i | input | 1 | Byte read strobe |
| addr_i | input | ADDR_W | Direct offset |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after the read |
| err_o | output | 1 | One-cycle pulse after an invalid access |
| pll_param_o | output | 3*3*DW | Parameter bytes of the three synthesizers |

## Verification
The collision that matters is a host write to a synthesizer's data port landing on the same edge where that synthesizer's lock counter would expire. The bench lets a first parameter write start the count. It then issues the second write exactly LOCK_CYCLES clocks later and reads the data port at once. The lock bit must read clear, and the stored bytes must show both writes at the pointer positions that follow in sequence.

// File: rtl/dac_idx_pkg.sv
package dac_idx_pkg;
  localparam int NUM_PLL       = 3;
  localparam int PLL_BYTES     = 3;
  localparam int PTR_W         = 2;
  localparam int LOCK_BIT      = 6;
  localparam int OFS_INDEX     = 'h00;
  localparam int OFS_DATA      = 'h0A;
  localparam int EXT_PLL_ADDR  = 'h2C;
  localparam int EXT_PLL_DATA0 = 'h2D;

  typedef enum logic [2:0] {
    ACC_BAD,
    ACC_IDX,
    ACC_DIR,
    ACC_EXT,
    ACC_PADDR,
    ACC_PDATA
  } acc_kind_e;
endpackage

// File: rtl/dac_idx_decode.sv
module dac_idx_decode
  import dac_idx_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DW     = 8,
  parameter int DIR_AW = 4,
  parameter int EXT_AW = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     index_i,
  output acc_kind_e         kind_o,
  output logic [PTR_W-1:0]  pll_sel_o
);
  localparam logic [DIR_AW-1:0] OFS_IDX_L = DIR_AW'(OFS_INDEX);
  localparam logic [DIR_AW-1:0] OFS_DAT_L = DIR_AW'(OFS_DATA);
  localparam logic [EXT_AW-1:0] X_PADDR   = EXT_AW'(EXT_PLL_ADDR);
  localparam logic [EXT_AW-1:0] X_PD_FIRST = EXT_AW'(EXT_PLL_DATA0);
  localparam logic [EXT_AW-1:0] X_PD_LAST  = EXT_AW'(EXT_PLL_DATA0 + NUM_PLL - 1);

  logic [DIR_AW-1:0] ofs;
  logic [EXT_AW-1:0] ext;

  assign ofs       = addr_i[DIR_AW-1:0];
  assign ext       = index_i[EXT_AW-1:0];
  assign pll_sel_o = PTR_W'(ext - X_PD_FIRST);

  always_comb begin
    kind_o = ACC_BAD;
    if ((addr_i >> DIR_AW) == '0) begin
      if (ofs == OFS_IDX_L) begin
        kind_o = ACC_IDX;
      end else if (ofs == OFS_DAT_L) begin
        if ((index_i >> EXT_AW) != '0)                   kind_o = ACC_BAD;
        else if (ext == X_PADDR)                         kind_o = ACC_PADDR;
        else if (ext >= X_PD_FIRST && ext <= X_PD_LAST)  kind_o = ACC_PDATA;
        else                                             kind_o = ACC_EXT;
      end else begin
        kind_o = ACC_DIR;
      end
    end
  end
endmodule

// File: rtl/dac_idx_regfile.sv
module dac_idx_regfile #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem_q[i] <= '0;
      else if (we_i && waddr_i == AW'(i))       mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dac_idx_pll.sv
module dac_idx_pll
  import dac_idx_pkg::*;
#(
  parameter int DW          = 8,
  parameter int LOCK_CYCLES = 16,
  localparam int CNT_W      = $clog2(LOCK_CYCLES + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ptr_load_i,
  input  logic [PTR_W-1:0]      ptr_val_i,
  input  logic                  acc_i,
  input  logic                  wr_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [PTR_W-1:0]      ptr_o,
  output logic [DW-1:0]         rdata_o,
  output logic                  lock_o,
  output logic                  restart_o,
  output logic [PLL_BYTES*DW-1:0] param_o
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(PLL_BYTES - 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(LOCK_CYCLES);

  logic [PTR_W-1:0] ptr_q;
  logic [DW-1:0]    byte_q [PLL_BYTES];
  logic [CNT_W-1:0] cnt_q;
  logic             lock_q;
  logic             hit;

  assign hit       = ptr_q <= PTR_LAST;
  assign restart_o = acc_i && wr_i && hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ptr_q <= '0;
    else if (ptr_load_i) ptr_q <= ptr_val_i;
    else if (acc_i)      ptr_q <= (ptr_q >= PTR_LAST) ? '0 : ptr_q + 1'b1;
  end

  for (genvar j = 0; j < PLL_BYTES; j++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               byte_q[j] <= '0;
      else if (restart_o && ptr_q == PTR_W'(j))  byte_q[j] <= wdata_i;
    end
    assign param_o[j*DW +: DW] = byte_q[j];
  end

  // restart has priority over expiry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CNT_INIT;
      lock_q <= 1'b0;
    end else if (restart_o) begin
      cnt_q  <= CNT_INIT;
      lock_q <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) lock_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int j = 0; j < PLL_BYTES; j++)
      if (ptr_q == PTR_W'(j)) rdata_o = byte_q[j];
    rdata_o[LOCK_BIT] = lock_q;
  end

  assign ptr_o  = ptr_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/dac_idx_port.sv
module dac_idx_port
  import dac_idx_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DW          = 8,
  parameter int DIR_AW      = 4,
  parameter int EXT_AW      = 6,
  parameter int LOCK_CYCLES = 16
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic                            rd_en_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DW-1:0]                   wdata_i,
  output logic [DW-1:0]                   rdata_o,
  output logic                            rvalid_o,
  output logic                            err_o,
  output logic [NUM_PLL*PLL_BYTES*DW-1:0] pll_param_o
);
  localparam int DIR_DEPTH = 1 << DIR_AW;
  localparam int EXT_DEPTH = 1 << EXT_AW;
  localparam int PB_W      = PLL_BYTES * DW;

  acc_kind_e        kind;
  logic [PTR_W-1:0] pll_sel;
  logic             wr, rd;
  logic [DW-1:0]    idx_q;
  logic [DW-1:0]    dir_rd, ext_rd, paddr_rd, pdata_rd, rdata_d;
  logic [DW-1:0]    rdata_q;
  logic             rvalid_q, err_q;

  logic [PTR_W-1:0] pll_ptr [NUM_PLL];
  logic [DW-1:0]    pll_rd  [NUM_PLL];
  logic [NUM_PLL-1:0] pll_lock, pll_restart;

  // write wins over a simultaneous read
  assign wr = wr_en_i;
  assign rd = rd_en_i && !wr_en_i;

  dac_idx_decode #(
    .ADDR_W(ADDR_W), .DW(DW), .DIR_AW(DIR_AW), .EXT_AW(EXT_AW)
  ) u_dec (
    .addr_i   (addr_i),
    .index_i  (idx_q),
    .kind_o   (kind),
    .pll_sel_o(pll_sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    idx_q <= '0;
    else if (wr && kind == ACC_IDX) idx_q <= wdata_i;
  end

  dac_idx_regfile #(.DEPTH(DIR_DEPTH), .DW(DW)) u_dir (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr && kind == ACC_DIR),
    .waddr_i(addr_i[DIR_AW-1:0]),
    .wdata_i(wdata_i),
    .raddr_i(addr_i[DIR_AW-1:0]),
    .rdata_o(dir_rd)
  );

  dac_idx_regfile #(.DEPTH(EXT_DEPTH), .DW(DW)) u_ext (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr && kind == ACC_EXT),
    .waddr_i(idx_q[EXT_AW-1:0]),
    .wdata_i(wdata_i),
    .raddr_i(idx_q[EXT_AW-1:0]),
    .rdata_o(ext_rd)
  );

  for (genvar k = 0; k < NUM_PLL; k++) begin : g_pll
    dac_idx_pll #(.DW(DW), .LOCK_CYCLES(LOCK_CYCLES)) u_pll (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ptr_load_i(wr && kind == ACC_PADDR),
      .ptr_val_i (wdata_i[k*PTR_W +: PTR_W]),
      .acc_i     ((wr || rd) && kind == ACC_PDATA && pll_sel == PTR_W'(k)),
      .wr_i      (wr),
      .wdata_i   (wdata_i),
      .ptr_o     (pll_ptr[k]),
      .rdata_o   (pll_rd[k]),
      .lock_o    (pll_lock[k]),
      .restart_o (pll_restart[k]),
      .param_o   (pll_param_o[k*PB_W +: PB_W])
    );
  end

  always_comb begin
    paddr_rd = '0;
    pdata_rd = '0;
    for (int k = 0; k < NUM_PLL; k++) begin
      paddr_rd[k*PTR_W +: PTR_W] = pll_ptr[k];
      if (pll_sel == PTR_W'(k)) pdata_rd = pll_rd[k];
    end
  end

  always_comb begin
    unique case (kind)
      ACC_IDX:   rdata_d = idx_q;
      ACC_DIR:   rdata_d = dir_rd;
      ACC_EXT:   rdata_d = ext_rd;
      ACC_PADDR: rdata_d = paddr_rd;
      ACC_PDATA: rdata_d = pdata_rd;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rvalid_q <= rd;
      err_q    <= (wr || rd) && kind == ACC_BAD;
      if (rd) rdata_q <= rdata_d;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign err_o    = err_q;
endmodule

// File: rtl/dac_idx_port_chk.sv
module dac_idx_port_chk
  import dac_idx_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DW          = 8,
  parameter int DIR_AW      = 4,
  parameter int LOCK_CYCLES = 16,
  localparam int CNT_W      = $clog2(LOCK_CYCLES + 1)
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            wr_en_i,
  input logic                            rd_en_i,
  input logic [ADDR_W-1:0]               addr_i,
  input logic [DW-1:0]                   rdata_o,
  input logic                            rvalid_o,
  input logic                            err_o,
  input logic [NUM_PLL*PLL_BYTES*DW-1:0] pll_param_o,
  input logic [NUM_PLL-1:0]              pll_lock,
  input logic [NUM_PLL-1:0]              pll_restart
);
  localparam logic [ADDR_W-1:0] DIR_END = ADDR_W'(1 << DIR_AW);

  p_rd_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !wr_en_i |=> rvalid_o);
  p_no_stray_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && !wr_en_i) |=> !rvalid_o);
  p_bad_dir_err_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i || wr_en_i) && addr_i >= DIR_END |=> err_o);
  p_err_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(rd_en_i || wr_en_i));
  p_bad_rd_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && err_o |-> rdata_o == '0);
  p_param_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(pll_param_o));

  for (genvar k = 0; k < NUM_PLL; k++) begin : g_lk
    logic [CNT_W-1:0] age_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             age_q <= '0;
      else if (pll_restart[k])                 age_q <= '0;
      else if (age_q != CNT_W'(LOCK_CYCLES))   age_q <= age_q + 1'b1;
    end
    p_lock_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pll_restart[k] |=> !pll_lock[k]);
    p_lock_time_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pll_lock[k] == (age_q == CNT_W'(LOCK_CYCLES)));
  end
endmodule

bind dac_idx_port dac_idx_port_chk #(
  .ADDR_W(ADDR_W), .DW(DW), .DIR_AW(DIR_AW), .LOCK_CYCLES(LOCK_CYCLES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .addr_i     (addr_i),
  .rdata_o    (rdata_o),
  .rvalid_o   (rvalid_o),
  .err_o      (err_o),
  .pll_param_o(pll_param_o),
  .pll_lock   (pll_lock),
  .pll_restart(pll_restart)
);

// File: tb/dac_idx_port_tb.sv
`timescale 1ns/1ps
module dac_idx_port_tb;
  localparam int LOCK = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0, wdata = '0;
  logic [7:0]  rdata;
  logic        rvalid, err;
  logic [71:0] param;

  typedef struct {
    logic [7:0] data;
    logic       err;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  dac_idx_port #(.LOCK_CYCLES(LOCK)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .rd_en_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .err_o(err), .pll_param_o(param)
  );

  task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor: pop and compare each returned read
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 rvalid without read", {63'd0, rvalid}, 72'd0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rdata == e.data && err == e.err, e.tag, {63'd0, err, rdata}, {63'd0, e.err, e.data});
      end
    end
  end

  task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    chk(err == 1'b0, "R2 valid write raised error", {71'd0, err}, 72'd0);
  endtask

  task automatic wr_bad(input logic [7:0] a, input logic [7:0] d, input string tag);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    chk(err == 1'b1 && rvalid == 1'b0, tag, {70'd0, err, rvalid}, {70'd0, 2'b10});
  endtask

  task automatic do_rd(input logic [7:0] a, input logic [7:0] e, input logic e_err, input string tag);
    exp_t x;
    @(negedge clk); addr = a; rd = 1'b1;
    x.data = e; x.err = e_err; x.tag = tag;
    exp_q.push_back(x);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic ext_wr(input logic [7:0] i, input logic [7:0] d);
    do_wr(8'h00, i);
    do_wr(8'h0A, d);
  endtask

  task automatic ext_rd(input logic [7:0] i, input logic [7:0] e, input string tag);
    do_wr(8'h00, i);
    do_rd(8'h0A, e, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk(param == 72'd0, "R11 reset parameters", param, 72'd0);
    do_rd(8'h00, 8'h00, 1'b0, "R11 reset index");
    do_rd(8'h05, 8'h00, 1'b0, "R11 reset direct byte");
    ext_rd(8'h2C, 8'h00, "R11 reset pointers");

    // R1 direct window, R2 invalid offsets
    do_wr(8'h05, 8'h33);
    do_wr(8'h0F, 8'hCC);
    do_wr(8'h00, 8'h1D);
    wr_bad(8'h10, 8'h55, "R2 write at 0x10 no error");
    wr_bad(8'h15, 8'h99, "R2 write at 0x15 no error");
    do_rd(8'h00, 8'h1D, 1'b0, "R1 index readback after bad write");
    do_rd(8'h05, 8'h33, 1'b0, "R1 byte 0x05 after aliasing write");
    do_rd(8'h0F, 8'hCC, 1'b0, "R1 byte 0x0F");
    do_rd(8'h10, 8'h00, 1'b1, "R2 read at 0x10");
    do_rd(8'hFF, 8'h00, 1'b1, "R2 read at 0xFF");

    // R3 extended file, R4 invalid index
    ext_wr(8'h1D, 8'hA5);
    ext_wr(8'h3F, 8'h5A);
    ext_wr(8'h00, 8'h12);
    ext_rd(8'h1D, 8'hA5, "R3 ext 0x1D");
    ext_rd(8'h3F, 8'h5A, "R3 ext 0x3F");
    do_wr(8'h00, 8'h40);
    wr_bad(8'h0A, 8'h77, "R4 write index 0x40 no error");
    do_rd(8'h0A, 8'h00, 1'b1, "R4 read index 0x40");
    do_wr(8'h00, 8'h6C);
    wr_bad(8'h0A, 8'h3F, "R4 write index 0x6C no error");
    ext_rd(8'h00, 8'h12, "R4 ext 0x00 untouched");
    ext_rd(8'h2C, 8'h00, "R4 pointers untouched");

    // R7 R8 program pixel synthesizer
    ext_wr(8'h2C, 8'h00);
    ext_wr(8'h2D, 8'h91);
    do_wr(8'h0A, 8'h22);
    do_wr(8'h0A, 8'hB3);
    chk(param == 72'h000000_000000_B32291, "R7 pixel bytes", param, 72'h000000_000000_B32291);
    ext_rd(8'h2D, 8'h91, "R10 lock clear after write");
    repeat (24) @(negedge clk);
    ext_rd(8'h2D, 8'h62, "R9 byte1 with lock bit");
    ext_rd(8'h2C, 8'h02, "R8 pixel pointer after read");
    ext_rd(8'h2E, 8'h40, "R11 memory locked from reset");
    ext_rd(8'h2C, 8'h06, "R8 memory pointer independent");

    // R6 packed pointer load
    ext_wr(8'h2C, 8'h2A);
    ext_wr(8'h2F, 8'h55);
    chk(param == 72'h550000_000000_B32291, "R7 loop byte2", param, 72'h550000_000000_B32291);
    ext_rd(8'h2C, 8'h0A, "R6 R8 loop pointer wrapped");

    // R9 pointer value 3
    ext_wr(8'h2C, 8'h03);
    ext_wr(8'h2D, 8'hEE);
    chk(param == 72'h550000_000000_B32291, "R9 write at pointer 3 stored", param, 72'h550000_000000_B32291);
    ext_rd(8'h2C, 8'h00, "R8 pointer 3 moves to 0");
    ext_rd(8'h2D, 8'hD1, "R9 lock kept after pointer 3 write");

    // R10 rewrite on expiry edge
    ext_wr(8'h2C, 8'h00);
    do_wr(8'h00, 8'h2D);
    @(negedge clk); addr = 8'h0A; wdata = 8'h11; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    repeat (LOCK - 1) @(negedge clk);
    addr = 8'h0A; wdata = 8'h22; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    do_rd(8'h0A, 8'hB3, 1'b0, "R10 rewrite wins over expiry");
    chk(param == 72'h550000_000000_B32211, "R7 bytes after collision", param, 72'h550000_000000_B32211);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5 reads without data", 72'(exp_q.size()), 72'd0);
    summary();
  end
endmodule